// File: doc/BRIEF.md
# Error Code Event Classifier Register

This block turns a stream of signed error codes into a latched byte of event flags. Each valid code is sorted by numeric range into one of four error classes: command, execution, device-dependent or query. The matching flag sets and stays set. A separate strobe reports that every pending operation has finished, and it sets its own flag.

The flags stay set until software reads the register, which clears it, or issues a clear-status strobe. An 8-bit mask chooses which flags raise the summary output. The summary feeds a higher-level status byte. Storing the error codes themselves is left to the error queue outside this block.

Top module: `err_event_status`

## Requirements
- R1: A pulse on `opc_done_i` sets event bit 0 in the following cycle.
- R2: A valid code from -499 to -400 inclusive sets event bit 2 (query error).
- R3: A valid code from -399 to -300 inclusive, or from 1 to 32767 inclusive, sets event bit 3 (device-dependent error).
- R4: A valid code from -299 to -200 inclusive sets event bit 4 (execution error).
- R5: A valid code from -199 to -100 inclusive sets event bit 5 (command error).
- R6: Event bits 1, 6 and 7 always read 0.
- R7: Event bits stay set until `rd_i` or `clr_i` is sampled high. After that, every bit not newly set in that same cycle reads 0.
- R8: `summary_o` equals the OR over all bits of (`event_o` AND `enable_o`).
- R9: The following change no event bit:
  - a code outside every listed range, including 0, -500, -99 and -32768;
  - any code presented while `err_valid_i` is low.
- R10: A bit set in the same cycle as a read-clear or a clear-status is kept.
- R11: `enable_o` resets to 0 and loads `en_wdata_i` when `en_we_i` is high. It is not changed by `clr_i` or `rd_i`.
- R12: Reset clears every event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_code_i | input | CODE_W | Signed error code |
| err_valid_i | input | 1 | Error code strobe |
| opc_done_i | input | 1 | Operations-complete strobe |
| rd_i | input | 1 | Read strobe; clears the event register |
| clr_i | input | 1 | Clear-status strobe |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| event_o | output | 8 | Latched event register |
| enable_o | output | 8 | Enable register |
| summary_o | output | 1 | Summary bit |

## Verification
The bench builds the block with its default 16-bit code width. At that width the extreme codes -32768 and 32767 can be driven directly. The bench applies every range edge (-500, -499, -400, -399, -300, -299, -200, -199, -100, -99, 0, 1) as a directed case. Random traffic then mixes codes clustered around the negative classes with codes from the full signed range, together with random reads, clears and enable writes.

// File: rtl/err_event_pkg.sv
package err_event_pkg;
  localparam int EVT_W    = 8;
  localparam int N_CLASS  = 5;
  localparam int BIT_OPC  = 0;
  // class ranges: lo, hi, target event bit
  localparam int CLS_LO  [N_CLASS] = '{-499, -399, 1,     -299, -199};
  localparam int CLS_HI  [N_CLASS] = '{-400, -300, 32767, -200, -100};
  localparam int CLS_BIT [N_CLASS] = '{2,    3,    3,     4,    5};
endpackage

// File: rtl/err_code_classify.sv
module err_code_classify
  import err_event_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic signed [CODE_W-1:0] code_i,
  input  logic                     valid_i,
  input  logic                     opc_i,
  output logic [EVT_W-1:0]         set_o
);
  logic [N_CLASS-1:0] hit;

  for (genvar g = 0; g < N_CLASS; g++) begin : g_cls
    assign hit[g] = valid_i && (int'(code_i) >= CLS_LO[g]) && (int'(code_i) <= CLS_HI[g]);
  end

  always_comb begin
    set_o = '0;
    set_o[BIT_OPC] = opc_i;
    for (int i = 0; i < N_CLASS; i++) begin
      if (hit[i]) set_o[CLS_BIT[i]] = 1'b1;
    end
  end
endmodule

// File: rtl/err_event_latch.sv
module err_event_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (clr_i ? '0 : q_o) | set_i;  // new set wins over clear
  end
endmodule

// File: rtl/err_event_summary.sv
module err_event_summary #(
  parameter int W = 8
) (
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  output logic         sum_o
);
  assign sum_o = |(evt_i & en_i);
endmodule

// File: rtl/err_event_status.sv
module err_event_status
  import err_event_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [CODE_W-1:0] err_code_i,
  input  logic                     err_valid_i,
  input  logic                     opc_done_i,
  input  logic                     rd_i,
  input  logic                     clr_i,
  input  logic                     en_we_i,
  input  logic [EVT_W-1:0]         en_wdata_i,
  output logic [EVT_W-1:0]         event_o,
  output logic [EVT_W-1:0]         enable_o,
  output logic                     summary_o
);
  logic [EVT_W-1:0] set_vec;

  err_code_classify #(.CODE_W(CODE_W)) u_cls (
    .code_i (err_code_i),
    .valid_i(err_valid_i),
    .opc_i  (opc_done_i),
    .set_o  (set_vec)
  );

  err_event_latch #(.W(EVT_W)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (rd_i | clr_i),
    .q_o   (event_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      enable_o <= '0;
    else if (en_we_i) enable_o <= en_wdata_i;
  end

  err_event_summary #(.W(EVT_W)) u_sum (
    .evt_i(event_o),
    .en_i (enable_o),
    .sum_o(summary_o)
  );
endmodule

// File: rtl/err_event_status_chk.sv
module err_event_status_chk #(
  parameter int CODE_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic signed [CODE_W-1:0] err_code_i,
  input logic                     err_valid_i,
  input logic                     opc_done_i,
  input logic                     rd_i,
  input logic                     clr_i,
  input logic                     en_we_i,
  input logic [7:0]               event_o,
  input logic [7:0]               enable_o,
  input logic                     summary_o
);
  AST_OPC_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opc_done_i |=> event_o[0]);  // R1
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o[1] == 1'b0) && (event_o[7:6] == 2'b00));  // R6
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !clr_i) |=> ((event_o & $past(event_o)) == $past(event_o)));  // R7
  AST_SUM_ZERO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_o == 8'h00) |-> !summary_o);  // R8
  AST_ZERO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !opc_done_i && (!err_valid_i || err_code_i == 0)) |=> (event_o == 8'h00));  // R9
  AST_CLR_KEEP_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || clr_i) && err_valid_i && int'(err_code_i) >= -199 && int'(err_code_i) <= -100)
    |=> event_o[5]);  // R10
  AST_EN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(enable_o));  // R11
endmodule

bind err_event_status err_event_status_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .err_code_i (err_code_i),
  .err_valid_i(err_valid_i),
  .opc_done_i (opc_done_i),
  .rd_i       (rd_i),
  .clr_i      (clr_i),
  .en_we_i    (en_we_i),
  .event_o    (event_o),
  .enable_o   (enable_o),
  .summary_o  (summary_o)
);

// File: tb/err_event_status_tb_top.sv
module err_event_status_tb_top;
  localparam int CODE_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [CODE_W-1:0] code = '0;
  logic valid = 1'b0, opc = 1'b0, rd = 1'b0, clr = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] evt, en;
  logic sum;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_evt = '0, m_en = '0;

  always #5 clk = ~clk;

  err_event_status #(.CODE_W(CODE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .err_code_i(code), .err_valid_i(valid),
    .opc_done_i(opc), .rd_i(rd), .clr_i(clr), .en_we_i(we), .en_wdata_i(wdata),
    .event_o(evt), .enable_o(en), .summary_o(sum)
  );

  function automatic logic [7:0] cls(int c, logic v);
    logic [7:0] r = '0;
    if (v) begin
      if (c >= -499 && c <= -400) r[2] = 1'b1;
      if ((c >= -399 && c <= -300) || (c >= 1 && c <= 32767)) r[3] = 1'b1;
      if (c >= -299 && c <= -200) r[4] = 1'b1;
      if (c >= -199 && c <= -100) r[5] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, sample 1ns after posedge
  task automatic cyc(int c, logic v, logic o, logic r, logic cl, logic w, logic [7:0] wd);
    @(negedge clk);
    code = CODE_W'(c); valid = v; opc = o; rd = r; clr = cl; we = w; wdata = wd;
    @(posedge clk);
    m_evt = ((r || cl) ? 8'h00 : m_evt) | cls(c, v) | {7'b0, o};
    if (w) m_en = wd;
    #1;
    valid = 0; opc = 0; rd = 0; clr = 0; we = 0;
  endtask

  task automatic cmp(string tag);
    chk({tag, " event"}, {24'b0, evt}, {24'b0, m_evt});
    chk({tag, " enable"}, {24'b0, en}, {24'b0, m_en});
    chk({tag, " summary"}, {31'b0, sum}, {31'b0, |(m_evt & m_en)});
  endtask

  task automatic one(string tag, int c, logic [7:0] exp);
    cyc(0, 0, 0, 1, 0, 0, 0);  // read-clear
    cyc(c, 1, 0, 0, 0, 0, 0);
    chk(tag, {24'b0, evt}, {24'b0, exp});
  endtask

  initial begin : watchdog
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #23 rst_n = 1'b1;
    #1;
    chk("R12 reset event", {24'b0, evt}, 32'h0);
    chk("R11 reset enable", {24'b0, en}, 32'h0);

    cyc(0, 0, 1, 0, 0, 0, 0);
    chk("R1 opc", {24'b0, evt}, 32'h01);

    one("R2 -499", -499, 8'h04);
    one("R2 -400", -400, 8'h04);
    one("R3 -399", -399, 8'h08);
    one("R3 -300", -300, 8'h08);
    one("R3 1", 1, 8'h08);
    one("R3 32767", 32767, 8'h08);
    one("R4 -299", -299, 8'h10);
    one("R4 -200", -200, 8'h10);
    one("R5 -199", -199, 8'h20);
    one("R5 -100", -100, 8'h20);
    one("R9 0", 0, 8'h00);
    one("R9 -500", -500, 8'h00);
    one("R9 -99", -99, 8'h00);
    one("R9 -32768", -32768, 8'h00);

    cyc(0, 0, 0, 1, 0, 0, 0);
    cyc(-150, 0, 0, 0, 0, 0, 0);
    chk("R9 invalid ignored", {24'b0, evt}, 32'h0);

    cyc(-450, 1, 0, 0, 0, 0, 0);
    cyc(-250, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R7 latch", {24'b0, evt}, 32'h14);

    cyc(-150, 1, 0, 1, 0, 0, 0);
    chk("R10 read keeps new", {24'b0, evt}, 32'h20);
    cyc(-350, 1, 0, 0, 1, 0, 0);
    chk("R10 clr keeps new", {24'b0, evt}, 32'h08);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R7 clr clears", {24'b0, evt}, 32'h0);

    cyc(0, 0, 0, 0, 0, 1, 8'h10);
    cyc(-250, 1, 0, 0, 0, 0, 0);
    chk("R8 summary on", {31'b0, sum}, 32'h1);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R11 enable after clr", {24'b0, en}, 32'h10);
    chk("R8 summary off", {31'b0, sum}, 32'h0);
    cyc(-450, 1, 0, 1, 0, 0, 0);
    chk("R11 enable after rd", {24'b0, en}, 32'h10);
    chk("R8 masked", {31'b0, sum}, 32'h0);

    for (int i = 0; i < 400; i++) begin
      int c;
      if ($urandom_range(1, 0) == 1) c = $signed($urandom_range(700, 0)) - 600;
      else c = int'($signed(16'($urandom())));
      cyc(c, ($urandom_range(9, 0) < 6), ($urandom_range(9, 0) == 0),
          ($urandom_range(9, 0) < 2), ($urandom_range(19, 0) == 0),
          ($urandom_range(9, 0) == 0), 8'($urandom()));
      cmp("R7/R8 random");
      chk("R6 reserved", {29'b0, evt[7], evt[6], evt[1]}, 32'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule